// File: doc/BRIEF.md
# Receive Idle Timeout Detector

This block measures how long the receive line of a serial receiver has been quiet, counted in bit periods, so that frames of varying length can be delimited. A programmed 16-bit limit is loaded into a down-counter whenever a character completes. The counter then steps down once per baud tick. When the count of quiet bit periods reaches the limit, a sticky status flag is raised. An interrupt request follows that flag while a mask input allows it.

Software restarts the mechanism with one of two command pulses. The "hold" command clears the flag and parks the counter until the next character arrives. The "reload" command clears the flag and begins a fresh countdown at once. A limit of zero switches detection off. The baud generator, the receiver shifter and the register decode are outside this block. They appear only as single-cycle strobes.

Top module: `rx_idle_timer`

## Requirements
- R1: After synchronous reset, the flag and the interrupt are low and the counter is disarmed, so baud ticks alone never raise the flag until a character or a reload command arms it.
- R2: With a nonzero limit N, the flag rises on the clock edge of the N-th baud tick after the cycle that loaded the counter, and not before.
- R3: A limit of zero loaded by a character or by a reload command never raises the flag.
- R4: Each completed character that arrives while counting reloads the counter, so the N ticks are counted from the most recent character.
- R5: The flag stays high until a command clears it, and the interrupt is high exactly when both the flag and the mask input are high.
- R6: The hold command clears the flag on the next edge and stops counting, and baud ticks have no effect until the next character rearms the countdown.
- R7: The reload command clears the flag, loads the limit and starts counting at once without waiting for a character.
- R8: After a timeout the counter stays parked and does not wrap, and a later rearm counts the full programmed limit again.
- R9: When a command and a character strobe share a cycle, the flag is cleared and the character arms a full countdown.
- R10: A limit write changes nothing in a countdown already running and is used from the next load onward. A load in the same cycle as the write still uses the old limit.
- R11: Only baud ticks count. A tick in the same cycle as a load, and cycles without a tick, do not advance the countdown.
- R12: The full 16-bit limit of 65535 times out after exactly 65535 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| char_done | input | 1 | One-cycle pulse when a character has been received |
| lim_wr | input | 1 | Write strobe for the limit |
| lim_wdata | input | 16 | New limit in bit periods, 0 disables |
| cmd_hold | input | 1 | Clear the flag and wait for the next character |
| cmd_reload | input | 1 | Clear the flag and restart counting now |
| irq_mask | input | 1 | Interrupt enable |
| tmo_flag | output | 1 | Sticky timeout status |
| tmo_irq | output | 1 | Interrupt request |

## Verification
The counter and the arm bit are hidden. A fault in either shows up only as the flag rising one or more ticks early or late, rising when the counter should be disarmed, or staying low. This can go unseen for up to a whole programmed limit of ticks. The bench therefore checks the flag on the exact tick where it must rise and on the tick just before it. After every command it runs long idle stretches, and it compares a reference model on every cycle of a random mix, so that a fault is seen within one countdown.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_PARK   = 2'd1,
        ACT_LOAD   = 2'd2,
        ACT_STEP   = 2'd3
    } idle_act_e;

    typedef struct packed {
        logic tick;
        logic chr;
        logic hold;
        logic reload;
    } idle_evt_t;

    // A load (character or reload command) wins over hold, which wins over a step.
    function automatic idle_act_e pick_act(input idle_evt_t ev, input logic armed);
        if (ev.reload || ev.chr)
            return ACT_LOAD;
        else if (ev.hold)
            return ACT_PARK;
        else if (armed && ev.tick)
            return ACT_STEP;
        else
            return ACT_KEEP;
    endfunction

    function automatic logic flag_clear(input idle_evt_t ev);
        return ev.hold || ev.reload;
    endfunction

endpackage

// File: rtl/rx_idle_limit.sv
module rx_idle_limit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] limit
);
    logic [CNT_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst)
            limit_q <= '0;
        else if (wr)
            limit_q <= wdata;
    end

    assign limit = limit_q;

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(limit_q));
endmodule

// File: rtl/rx_idle_count.sv
module rx_idle_count
    import rx_idle_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  idle_evt_t        ev,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    idle_act_e        act;
    logic             armed_q, armed_n;
    logic [CNT_W-1:0] count_q, count_n;
    logic             at_last;

    assign act     = pick_act(ev, armed_q);
    assign at_last = (count_q == ONE);
    assign fire    = (act == ACT_STEP) && at_last;

    always_comb begin
        armed_n = armed_q;
        count_n = count_q;
        unique case (act)
            ACT_LOAD: begin
                count_n = limit;
                armed_n = (limit != '0);
            end
            ACT_PARK: armed_n = 1'b0;
            ACT_STEP: begin
                count_n = count_q - ONE;
                if (at_last)
                    armed_n = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            count_q <= '0;
        end else begin
            armed_q <= armed_n;
            count_q <= count_n;
        end
    end

    assert_zero_off_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.chr || ev.reload) && (limit == '0) |=> !armed_q);
    assert_fire_once_R8: assert property (@(posedge clk) disable iff (rst)
        fire |=> !armed_q && (count_q == '0));
    assert_parked_R11: assert property (@(posedge clk) disable iff (rst)
        !armed_q && !ev.chr && !ev.reload |=> $stable(count_q));
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        armed_q && ev.tick && !ev.chr && !ev.reload && !ev.hold
        |=> count_q == $past(count_q) - ONE);
endmodule

// File: rtl/rx_idle_flag.sv
module rx_idle_flag (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr,
    input  logic mask,
    output logic flag,
    output logic irq
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (clr)
            flag_q <= 1'b0;
        else if (fire)
            flag_q <= 1'b1;
    end

    assign flag = flag_q;
    assign irq  = flag_q & mask;

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        flag_q && !clr |=> flag_q);
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> !flag_q);
    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        fire && !clr |=> flag_q);
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import rx_idle_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             baud_tick,
    input  logic             char_done,
    input  logic             lim_wr,
    input  logic [CNT_W-1:0] lim_wdata,
    input  logic             cmd_hold,
    input  logic             cmd_reload,
    input  logic             irq_mask,
    output logic             tmo_flag,
    output logic             tmo_irq
);
    idle_evt_t        ev;
    logic [CNT_W-1:0] limit;
    logic             fire;

    assign ev = '{tick: baud_tick, chr: char_done, hold: cmd_hold, reload: cmd_reload};

    rx_idle_limit #(.CNT_W(CNT_W)) u_limit (
        .clk   (clk),
        .rst   (rst),
        .wr    (lim_wr),
        .wdata (lim_wdata),
        .limit (limit)
    );

    rx_idle_count #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .limit (limit),
        .fire  (fire)
    );

    rx_idle_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .clr  (flag_clear(ev)),
        .mask (irq_mask),
        .flag (tmo_flag),
        .irq  (tmo_irq)
    );

    assert_cmd_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_hold || cmd_reload) && char_done |=> !tmo_flag);
endmodule

// File: tb/rx_idle_timer_tb.sv
`timescale 1ns/1ps
module rx_idle_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        baud_tick = 0, char_done = 0, lim_wr = 0, cmd_hold = 0, cmd_reload = 0;
    logic        irq_mask = 1'b1;
    logic [15:0] lim_wdata = '0;
    logic        tmo_flag, tmo_irq;

    int n_chk = 0, n_bad = 0;
    bit chk_model = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_limit = '0, m_cnt = '0;
    logic        m_armed = 0, m_flag = 0;

    always #2 clk = ~clk;

    rx_idle_timer u_dut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .char_done(char_done),
        .lim_wr(lim_wr), .lim_wdata(lim_wdata), .cmd_hold(cmd_hold),
        .cmd_reload(cmd_reload), .irq_mask(irq_mask),
        .tmo_flag(tmo_flag), .tmo_irq(tmo_irq)
    );

    function automatic logic exp_irq(input logic f, input logic m);
        return f & m;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic t, c, h, r, w, input logic [15:0] d);
        if (h || r) m_flag = 1'b0;
        if (r || c) begin
            m_cnt   = m_limit;
            m_armed = (m_limit != 16'd0);
        end else if (h) begin
            m_armed = 1'b0;
        end else if (m_armed && t) begin
            m_cnt = m_cnt - 16'd1;
            if (m_cnt == 16'd0) begin
                m_flag  = 1'b1;
                m_armed = 1'b0;
            end
        end
        if (w) m_limit = d;
    endtask

    task automatic cyc(input logic t, c, h, r, w, input logic [15:0] d);
        baud_tick = t; char_done = c; cmd_hold = h; cmd_reload = r; lim_wr = w; lim_wdata = d;
        @(posedge clk);
        model_step(t, c, h, r, w, d);
        @(negedge clk);
        baud_tick = 0; char_done = 0; cmd_hold = 0; cmd_reload = 0; lim_wr = 0;
        if (chk_model) begin
            check(tmo_flag === m_flag, "R2 R4 model flag", tmo_flag, m_flag);
            check(tmo_irq === exp_irq(m_flag, irq_mask), "R5 model irq", tmo_irq, exp_irq(m_flag, irq_mask));
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 16'd0);
    endtask

    task automatic expect_flag(input logic e, input string tag);
        check(tmo_flag === e, tag, tmo_flag, e);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_flag(0, "R1 flag after reset");
        check(tmo_irq === 1'b0, "R1 irq after reset", tmo_irq, 0);
        cyc(0, 0, 0, 0, 1, 16'd5);
        ticks(20);
        expect_flag(0, "R1 ticks without arming");

        // R2 exact edge, R5 mask and stickiness
        cyc(0, 1, 0, 0, 0, 16'd0);
        ticks(4); expect_flag(0, "R2 tick before limit");
        ticks(1); expect_flag(1, "R2 tick at limit");
        check(tmo_irq === 1'b1, "R5 irq with mask", tmo_irq, 1);
        irq_mask = 1'b0; #1;
        check(tmo_irq === 1'b0, "R5 irq masked", tmo_irq, 0);
        irq_mask = 1'b1; #1;
        ticks(30); expect_flag(1, "R5 flag sticky");

        // R6 hold
        cyc(0, 0, 1, 0, 0, 16'd0); expect_flag(0, "R6 hold clears");
        ticks(20); expect_flag(0, "R6 parked after hold");
        cyc(0, 1, 0, 0, 0, 16'd0);
        ticks(4); expect_flag(0, "R6 char rearms early");
        ticks(1); expect_flag(1, "R6 char rearms at limit");

        // R7 reload
        cyc(0, 0, 0, 1, 0, 16'd0); expect_flag(0, "R7 reload clears");
        ticks(4); expect_flag(0, "R7 before limit");
        ticks(1); expect_flag(1, "R7 at limit");

        // R9 command and character together
        ticks(15);
        cyc(0, 1, 1, 0, 0, 16'd0); expect_flag(0, "R9 hold with char clears");
        ticks(4); expect_flag(0, "R9 before limit");
        ticks(1); expect_flag(1, "R9 char armed countdown");

        // R8 no wrap after a timeout
        ticks(70);
        cyc(0, 0, 1, 0, 0, 16'd0); expect_flag(0, "R8 clear");
        cyc(0, 1, 0, 0, 0, 16'd0);
        ticks(4); expect_flag(0, "R8 full count early");
        ticks(1); expect_flag(1, "R8 full count at limit");

        // R4 character restarts the count
        cyc(0, 0, 1, 0, 0, 16'd0);
        cyc(0, 1, 0, 0, 0, 16'd0);
        ticks(3);
        cyc(0, 1, 0, 0, 0, 16'd0);
        ticks(4); expect_flag(0, "R4 restarted count");
        ticks(1); expect_flag(1, "R4 limit from last char");

        // R11 only ticks count, tick during load ignored
        cyc(0, 0, 1, 0, 0, 16'd0);
        cyc(1, 1, 0, 0, 0, 16'd0);
        for (int i = 0; i < 4; i++) begin
            cyc(0, 0, 0, 0, 0, 16'd0);
            cyc(1, 0, 0, 0, 0, 16'd0);
        end
        expect_flag(0, "R11 gaps and load tick");
        ticks(1); expect_flag(1, "R11 fifth tick");

        // R10 limit write during a countdown
        cyc(0, 0, 1, 0, 0, 16'd0);
        cyc(0, 1, 0, 0, 0, 16'd0);
        ticks(2);
        cyc(0, 0, 0, 0, 1, 16'd20);
        ticks(2); expect_flag(0, "R10 old limit early");
        ticks(1); expect_flag(1, "R10 old limit kept");
        cyc(0, 0, 0, 1, 0, 16'd0);
        ticks(19); expect_flag(0, "R10 new limit early");
        ticks(1); expect_flag(1, "R10 new limit used");

        // R3 zero disables
        cyc(0, 0, 0, 0, 1, 16'd0);
        cyc(0, 0, 1, 0, 0, 16'd0);
        cyc(0, 1, 0, 0, 0, 16'd0);
        ticks(200); expect_flag(0, "R3 zero after char");
        cyc(0, 0, 0, 1, 0, 16'd0);
        ticks(200); expect_flag(0, "R3 zero after reload");

        // R12 full width
        cyc(0, 0, 0, 0, 1, 16'hFFFF);
        cyc(0, 0, 0, 1, 0, 16'd0);
        ticks(65534); expect_flag(0, "R12 one tick short");
        ticks(1); expect_flag(1, "R12 at 65535");

        // random mix against the model
        cyc(0, 0, 0, 0, 1, 16'd3);
        chk_model = 1;
        for (int i = 0; i < 5000; i++) begin
            logic t, c, h, r, w;
            logic [15:0] d;
            t = ($urandom % 2) == 0;
            c = ($urandom % 20) == 0;
            h = ($urandom % 50) == 0;
            r = ($urandom % 50) == 0;
            w = ($urandom % 40) == 0;
            d = 16'($urandom % 12);
            if (($urandom % 64) == 0) irq_mask = ~irq_mask;
            cyc(t, c, h, r, w, d);
        end

        finish_run();
    end
endmodule